// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial memory slave and owns the write side of the storage array. When the bus engine decodes a write header it passes the word address in; every data byte that follows is placed into a small page buffer at the in-page column held by a column counter. That counter wraps inside the page and never carries into the row bits. A mask beside the buffer records which columns were actually loaded.

A STOP that follows at least one loaded byte starts a self-timed write cycle. During that cycle the block raises a busy flag, which the bus engine uses to withhold every acknowledge, and copies only the loaded columns into the array, one column per clock in ascending order. A START that arrives before the STOP throws the loaded bytes away and writes nothing. A high write-protect pin keeps every array location unchanged.

The density parameter picks the page size and the address width. The write-cycle length is a parameter counted in clock cycles, so a bench can use a short cycle.

Top module: `page_commit_buf`

## Requirements
- R1: The page holds 8 bytes when DENSITY_KBIT is 1 or 2 and 16 bytes when it is 4, 8 or 16. The word address is 7 + log2(DENSITY_KBIT) bits wide, and its low log2(page) bits are the column. A committed byte goes to the address made of the header's row bits followed by its column.
- R2: Each data byte taken during a write transaction produces a one-cycle `data_ack` pulse in the cycle after its strobe. `data_ack` is never high otherwise.
- R3: After each taken byte the column advances by one and wraps from the last column to column 0 of the same row. The row bits never change.
- R4: A byte taken at a column that is already loaded replaces the earlier byte at that column.
- R5: A STOP during a write transaction with at least one loaded byte raises `busy` in the next cycle. `busy` then stays high for exactly max(WR_CYCLES, page size) cycles.
- R6: While busy, busy cycle k (counting from 0) writes column k if that column was loaded, for k below the page size. Unloaded columns are never written, and `mem_we` is never high outside busy.
- R7: While busy, header, data, STOP and START strobes are ignored: no acknowledge, no change to the buffer, and no further write cycle.
- R8: `mem_we` is never high while `wp_pin` is high.
- R9: A START during a write transaction, before any STOP, discards the loaded bytes. No write cycle follows and nothing is written.
- R10: A STOP during a write transaction with no loaded byte ends the transaction without raising `busy`.
- R11: During and straight after reset, `busy`, `data_ack` and `mem_we` are low and no transaction is open.
- R12: The loaded-byte mask is cleared at each new write header, so bytes of an earlier transaction are never committed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_hdr_stb | input | 1 | One-cycle strobe: a write header was decoded |
| wr_hdr_addr | input | ADDR_W | Word address that comes with the header |
| data_stb | input | 1 | One-cycle strobe: a data byte was received |
| data_byte | input | 8 | Received data byte |
| stop_stb | input | 1 | One-cycle strobe: STOP seen on the bus |
| start_stb | input | 1 | One-cycle strobe: START seen on the bus |
| wp_pin | input | 1 | Write protect; high blocks every array write |
| busy | output | 1 | High for the whole self-timed write cycle |
| data_ack | output | 1 | Pulse: the previous data byte is acknowledged |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
`data_ack` is due one cycle after the clock edge that samples a data strobe. `busy` rises one cycle after the edge that samples STOP and falls exactly max(WR_CYCLES, page) cycles later. Busy cycle k carries the write for column k, as a combinational output of registered state and the live write-protect pin. A behavioural model in the bench steps on the same rising edge as the design. Every output is compared against it at the falling edge, after the design's registers have settled and before the next inputs change. Array contents collected from the write port are then checked against values worked out by hand for wrap, overwrite, protect, abort and mask-clear cases.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } pcb_state_e;

  // R1: small densities use an 8-byte page, larger ones 16 bytes
  function automatic int pcb_page_bytes(int kbit);
    return (kbit <= 2) ? 8 : 16;
  endfunction

  function automatic int pcb_addr_bits(int kbit);
    return 7 + $clog2(kbit);
  endfunction

  function automatic int pcb_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcb_addr_track.sv
module pcb_addr_track #(
  parameter int ADDR_W = 8,
  parameter int COL_W  = 3,
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_ld,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              adv,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q
);

  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic             upd_en;

  // R3: only the column advances, wrapping inside the row
  always_comb begin
    upd_en = hdr_ld | adv;
    if (hdr_ld) begin
      row_d = hdr_addr[ADDR_W-1:COL_W];
      col_d = hdr_addr[COL_W-1:0];
    end else begin
      row_d = row_q;
      col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (upd_en) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

endmodule

// File: rtl/pcb_page_store.sv
module pcb_page_store #(
  parameter int PAGE_BYTES = 8,
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [COL_W-1:0]      wr_col,
  input  logic [7:0]            wr_data,
  output logic [7:0]            ent_data [PAGE_BYTES],
  output logic [PAGE_BYTES-1:0] ent_valid
);

  logic [PAGE_BYTES-1:0] hit;
  logic [PAGE_BYTES-1:0] valid_d;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_hit
    assign hit[i] = wr_en && (wr_col == COL_W'(i));
  end

  // R12: a clear empties the mask; R4: a later hit simply reloads the entry
  always_comb begin
    if (clr) valid_d = '0;
    else     valid_d = ent_valid | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_valid <= '0;
    else        ent_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < PAGE_BYTES; k++) ent_data[k] <= '0;
    end else begin
      for (int k = 0; k < PAGE_BYTES; k++) begin
        if (hit[k]) ent_data[k] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/pcb_cycle_timer.sv
module pcb_cycle_timer #(
  parameter int CYCLES     = 40,
  parameter int PAGE_BYTES = 8,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             run_q,
  output logic             scan_en,
  output logic [COL_W-1:0] scan_idx
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_d;

  // R5: the count starts on go and ends after CYCLES busy cycles
  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (run_q) begin
      if (cnt_q == CNT_W'(CYCLES - 1)) run_d = 1'b0;
      else                             cnt_d = cnt_q + 1'b1;
    end else if (go) begin
      run_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // R6: the first PAGE_BYTES busy cycles each visit one column
  assign scan_en  = run_q && (cnt_q < CNT_W'(PAGE_BYTES));
  assign scan_idx = cnt_q[COL_W-1:0];

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import pcb_pkg::*;
#(
  parameter int DENSITY_KBIT = 2,
  parameter int WR_CYCLES    = 40,
  localparam int ADDR_W = pcb_addr_bits(DENSITY_KBIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hdr_stb,
  input  logic [ADDR_W-1:0] wr_hdr_addr,
  input  logic              data_stb,
  input  logic [7:0]        data_byte,
  input  logic              stop_stb,
  input  logic              start_stb,
  input  logic              wp_pin,
  output logic              busy,
  output logic              data_ack,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  localparam int PAGE_BYTES = pcb_page_bytes(DENSITY_KBIT);
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int ROW_W      = ADDR_W - COL_W;
  localparam int EFF_CYCLES = pcb_max(WR_CYCLES, PAGE_BYTES);

  pcb_state_e state_q, state_d;
  logic ack_d;
  logic hdr_take, abort_take, stop_take, byte_take, commit_go, mask_clr;
  logic in_load;

  logic [ROW_W-1:0]      row_q;
  logic [COL_W-1:0]      col_q;
  logic [7:0]            ent_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] ent_valid;
  logic                  scan_en;
  logic [COL_W-1:0]      scan_idx;

  // Strobe decode. Priority inside a transaction: header, START, STOP, data.
  // R7: nothing is taken while the write cycle runs.
  always_comb begin
    in_load    = (state_q == ST_LOAD);
    hdr_take   = wr_hdr_stb && !busy;
    abort_take = in_load && !wr_hdr_stb && start_stb;                          // R9
    stop_take  = in_load && !wr_hdr_stb && !start_stb && stop_stb;
    byte_take  = in_load && !wr_hdr_stb && !start_stb && !stop_stb && data_stb;
    commit_go  = stop_take && (|ent_valid);                                     // R5, R10
    mask_clr   = hdr_take || abort_take;                                        // R12
    ack_d      = byte_take;                                                     // R2
  end

  always_comb begin
    state_d = state_q;
    if (hdr_take)                      state_d = ST_LOAD;
    else if (abort_take || stop_take)  state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      data_ack <= 1'b0;
    end else begin
      state_q  <= state_d;
      data_ack <= ack_d;
    end
  end

  pcb_addr_track #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_ld   (hdr_take),
    .hdr_addr (wr_hdr_addr),
    .adv      (byte_take),
    .row_q    (row_q),
    .col_q    (col_q)
  );

  pcb_page_store #(
    .PAGE_BYTES (PAGE_BYTES)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mask_clr),
    .wr_en     (byte_take),
    .wr_col    (col_q),
    .wr_data   (data_byte),
    .ent_data  (ent_data),
    .ent_valid (ent_valid)
  );

  pcb_cycle_timer #(
    .CYCLES     (EFF_CYCLES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (commit_go),
    .run_q    (busy),
    .scan_en  (scan_en),
    .scan_idx (scan_idx)
  );

  // Array write port. R6: loaded columns only; R8: protect pin gates the strobe.
  always_comb begin
    mem_we    = scan_en && ent_valid[scan_idx] && !wp_pin;
    mem_addr  = {row_q, scan_idx};
    mem_wdata = ent_data[scan_idx];
  end

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
  import pcb_pkg::*;
#(
  parameter int DENSITY_KBIT = 2,
  parameter int WR_CYCLES    = 40,
  localparam int ADDR_W = pcb_addr_bits(DENSITY_KBIT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_hdr_stb,
  input logic [ADDR_W-1:0] wr_hdr_addr,
  input logic              data_stb,
  input logic [7:0]        data_byte,
  input logic              stop_stb,
  input logic              start_stb,
  input logic              wp_pin,
  input logic              busy,
  input logic              data_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata
);

  localparam int PAGE_BYTES = pcb_page_bytes(DENSITY_KBIT);
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int EFF_CYCLES = pcb_max(WR_CYCLES, PAGE_BYTES);

  int busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  a_r8_wp_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp_pin);

  a_r6_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_stb));

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == EFF_CYCLES));

  a_r2_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    data_ack |-> $past(data_stb));

  a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_ack);

  a_r3_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W])));

  a_r6_column_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy)) |-> (mem_addr[COL_W-1:0] == $past(mem_addr[COL_W-1:0]) + 1'b1));

endmodule

bind page_commit_buf pcb_checker #(
  .DENSITY_KBIT (DENSITY_KBIT),
  .WR_CYCLES    (WR_CYCLES)
) u_pcb_checker (.*);

// File: tb/test_page_commit_buf.sv
module test_page_commit_buf;

  localparam int DENS   = 2;
  localparam int WCYC   = 20;
  localparam int PAGE   = 8;
  localparam int AW     = 8;
  localparam int EFF    = 20;

  logic          clk;
  logic          rst_n;
  logic          wr_hdr_stb;
  logic [AW-1:0] wr_hdr_addr;
  logic          data_stb;
  logic [7:0]    data_byte;
  logic          stop_stb;
  logic          start_stb;
  logic          wp_pin;
  logic          busy;
  logic          data_ack;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  page_commit_buf #(.DENSITY_KBIT(DENS), .WR_CYCLES(WCYC)) i_page_commit_buf (
    .clk(clk), .rst_n(rst_n), .wr_hdr_stb(wr_hdr_stb), .wr_hdr_addr(wr_hdr_addr),
    .data_stb(data_stb), .data_byte(data_byte), .stop_stb(stop_stb),
    .start_stb(start_stb), .wp_pin(wp_pin), .busy(busy), .data_ack(data_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string tag    = "R11";

  // Behavioural reference model
  bit       m_load;
  int       m_row, m_col, m_left, m_el;
  bit [7:0] m_buf [PAGE];
  bit       m_val [PAGE];
  bit       m_ack;

  // Array image captured from the write port
  bit [7:0] img   [256];
  int       wcnt  [256];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = 0; m_row = 0; m_col = 0; m_left = 0; m_el = 0; m_ack = 0;
      for (int i = 0; i < PAGE; i++) begin m_buf[i] = 0; m_val[i] = 0; end
    end else begin
      m_ack = 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        m_el   = m_el + 1;
      end else if (wr_hdr_stb) begin
        m_load = 1;
        m_row  = int'(wr_hdr_addr) / PAGE;
        m_col  = int'(wr_hdr_addr) % PAGE;
        for (int i = 0; i < PAGE; i++) m_val[i] = 0;
      end else if (m_load && start_stb) begin
        m_load = 0;
        for (int i = 0; i < PAGE; i++) m_val[i] = 0;
      end else if (m_load && stop_stb) begin
        bit any;
        any = 0;
        for (int i = 0; i < PAGE; i++) any |= m_val[i];
        m_load = 0;
        if (any) begin m_left = EFF; m_el = 0; end
      end else if (m_load && data_stb) begin
        m_buf[m_col] = data_byte;
        m_val[m_col] = 1;
        m_col = (m_col + 1) % PAGE;
        m_ack = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit e_busy, e_we;
    e_busy = (m_left > 0);
    e_we   = e_busy && (m_el < PAGE) && m_val[m_el] && !wp_pin;
    chk(busy == e_busy, tag, "busy", int'(busy), int'(e_busy));
    chk(data_ack == m_ack, tag, "data_ack (R2)", int'(data_ack), int'(m_ack));
    chk(mem_we == e_we, tag, "mem_we (R6/R8)", int'(mem_we), int'(e_we));
    if (e_we && mem_we) begin
      chk(int'(mem_addr) == m_row * PAGE + m_el, tag, "mem_addr (R1)",
          int'(mem_addr), m_row * PAGE + m_el);
      chk(mem_wdata == m_buf[m_el], tag, "mem_wdata", int'(mem_wdata), int'(m_buf[m_el]));
    end
    if (mem_we) begin
      img[mem_addr] = mem_wdata;
      wcnt[mem_addr]++;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic hdr(input int a);
    wr_hdr_stb = 1; wr_hdr_addr = AW'(a); tick(); wr_hdr_stb = 0;
  endtask
  task automatic wrb(input int d);
    data_stb = 1; data_byte = 8'(d); tick(); data_stb = 0;
  endtask
  task automatic stp();
    stop_stb = 1; tick(); stop_stb = 0;
  endtask
  task automatic sta();
    start_stb = 1; tick(); start_stb = 0;
  endtask
  task automatic wait_idle();
    for (int n = 0; n < 200 && (m_left > 0 || busy); n++) tick();
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin img[i] = 0; wcnt[i] = 0; end
    rst_n = 0; wr_hdr_stb = 0; wr_hdr_addr = '0; data_stb = 0; data_byte = '0;
    stop_stb = 0; start_stb = 0; wp_pin = 0;
    tick(); tick();
    chk(busy == 0 && data_ack == 0 && mem_we == 0, "R11", "outputs in reset",
        int'({busy, data_ack, mem_we}), 0);
    rst_n = 1;
    tick();

    // R1, R2, R5, R6: partial page of three bytes
    tag = "R5";
    hdr(8'h12); wrb(8'hA0); wrb(8'hA1); wrb(8'hA2); stp();
    chk(busy == 1, "R5", "busy the cycle after STOP", int'(busy), 1);
    // R7: strobes during the write cycle are ignored
    tag = "R7";
    hdr(8'h50); wrb(8'hEE); stp(); sta();
    wait_idle();
    chk(img[8'h12] == 8'hA0, "R1", "array @12", int'(img[8'h12]), 8'hA0);
    chk(img[8'h14] == 8'hA2, "R6", "array @14", int'(img[8'h14]), 8'hA2);
    chk(wcnt[8'h15] == 0, "R6", "unloaded column @15 writes", wcnt[8'h15], 0);
    chk(wcnt[8'h50] == 0, "R7", "writes @50 issued while busy", wcnt[8'h50], 0);

    // R3, R4: ten bytes from column 6 wrap inside row 3
    tag = "R3";
    hdr(8'h1E);
    for (int k = 0; k < 10; k++) wrb(8'hB0 + k);
    stp();
    wait_idle();
    chk(img[8'h18] == 8'hB2, "R3", "wrapped column 0 @18", int'(img[8'h18]), 8'hB2);
    chk(img[8'h1E] == 8'hB8, "R4", "overwritten column 6 @1E", int'(img[8'h1E]), 8'hB8);
    chk(img[8'h1F] == 8'hB9, "R4", "overwritten column 7 @1F", int'(img[8'h1F]), 8'hB9);
    chk(wcnt[8'h20] == 0, "R3", "next row untouched @20", wcnt[8'h20], 0);

    // R8: protected write cycle
    tag = "R8";
    wp_pin = 1;
    hdr(8'h30); wrb(8'hC0); wrb(8'hC1); stp();
    wait_idle();
    chk(wcnt[8'h30] == 0 && wcnt[8'h31] == 0, "R8", "writes under protect",
        wcnt[8'h30] + wcnt[8'h31], 0);
    wp_pin = 0;

    // R9: START before STOP discards
    tag = "R9";
    hdr(8'h60); wrb(8'h11); wrb(8'h22); sta(); tick();
    chk(busy == 0, "R9", "busy after aborted write", int'(busy), 0);
    stp(); tick();
    chk(wcnt[8'h60] == 0, "R9", "writes @60 after abort", wcnt[8'h60], 0);

    // R10: header followed by STOP with no data
    tag = "R10";
    hdr(8'h70); stp(); tick();
    chk(busy == 0, "R10", "busy after empty write", int'(busy), 0);

    // R12: second transaction must not recommit the first one's byte
    tag = "R12";
    hdr(8'h40); wrb(8'h41); stp(); wait_idle();
    hdr(8'h43); wrb(8'h44); stp(); wait_idle();
    chk(wcnt[8'h40] == 1, "R12", "commits @40", wcnt[8'h40], 1);
    chk(img[8'h43] == 8'h44, "R12", "array @43", int'(img[8'h43]), 8'h44);

    // R2: acknowledge timing across back-to-back bytes with full page
    tag = "R2";
    hdr(8'h80);
    for (int k = 0; k < PAGE; k++) wrb(8'h90 + k);
    stp(); wait_idle();
    chk(img[8'h87] == 8'h97, "R2", "full page last column @87", int'(img[8'h87]), 8'h97);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule